// File: doc/BRIEF.md
# Rotating Omega Interconnect Network

This block is a multistage shuffle-exchange fabric with N input ports and N output ports, where N is a power of two. It carries fixed-width words between requesting ports and memory banks. The fabric has log2(N) columns. Each column is a perfect shuffle of the lanes followed by N/2 two-by-two exchange switches. All switches in one column follow a single shared control bit, and these bits together form a routing index.

The routing index comes from a free-running counter. The counter clears under reset and advances by one on every clock. Because every column is driven as a whole, the path is simple: input i always lands on output i XOR index. This mapping is its own inverse, so one index drives two copies of the fabric. The request copy runs from ports to banks, and the response copy runs from banks back to ports. Across any N consecutive cycles, every input meets every output once. The current index is exported so that queues outside the block know which destination each port faces in the present cycle.

A valid bit travels beside each word through every stage. A build-time option adds one output register to both copies. Buffering, back-pressure and the banks themselves all sit outside this block.

Top module: `rot_omega_net`

## Requirements
- R1: On the request path, output j carries the data word presented at input (j XOR route index) in the same cycle when the output register is off. Every data bit is passed unaltered.
- R2: On the response path, output j carries the valid bit and data word of response input (j XOR route index). This uses the same route index value as the request path in that cycle.
- R3: The route index is 0 while synchronous reset is high, including a reset applied mid-run. After reset it increases by 1 on each rising edge and wraps from N-1 to 0.
- R4: Over any N consecutive cycles with all inputs valid, each input index appears at each output exactly once.
- R5: The valid bit follows the same path as its data. An idle input (valid 0) gives an idle output, and the set of valid outputs is the routed image of the set of valid inputs.
- R6: With the output register on, outputs show the inputs of the previous cycle, routed by the index that was current in that previous cycle. Outputs do not follow input changes within a cycle, and reset clears every registered valid bit and data bit to 0.
- R7: In a single-column fabric (N=2), route index 0 passes each input straight to the output with the same number, and index 1 swaps the two inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | N_PORTS | Request valid per port |
| req_data_i | input | N_PORTS*DATA_W | Request words, port p at bits p*DATA_W upward |
| req_valid_o | output | N_PORTS | Request valid per bank |
| req_data_o | output | N_PORTS*DATA_W | Request words per bank |
| rsp_valid_i | input | N_PORTS | Response valid per bank |
| rsp_data_i | input | N_PORTS*DATA_W | Response words per bank |
| rsp_valid_o | output | N_PORTS | Response valid per port |
| rsp_data_o | output | N_PORTS*DATA_W | Response words per port |
| route_idx_o | output | log2(N_PORTS) | Current routing index |

## Verification
The bench targets the column-to-bit ordering first. If the shuffle direction or the column bit order were reversed, inputs would reach the wrong outputs for nonsymmetric indices such as 1 and 6. The bench catches this with distinct per-input tags. It also covers the wrap of the index from N-1 to 0 and a reset applied mid-run, since a counter that holds, skips or ignores reset would break the uniform port-to-bank schedule. Idle and partly-idle input masks expose a valid bit that is dropped or routed apart from its data. The registered variant is checked for exactly one cycle of latency using the old index, and for clearing under reset.

// File: rtl/omega_pkg.sv
`timescale 1ns/1ps
package omega_pkg;

    typedef enum logic {
        XCHG_PASS  = 1'b0,
        XCHG_CROSS = 1'b1
    } xchg_mode_e;

    // Source lane feeding shuffled position pos: rotate the index right by one bit.
    function automatic int shuffle_src(input int pos, input int lg);
        int low_bit;
        low_bit = pos & 1;
        return (pos >> 1) | (low_bit << (lg - 1));
    endfunction

endpackage

// File: rtl/omega_xchg.sv
`timescale 1ns/1ps
module omega_xchg #(
    parameter int LANE_W = 17
) (
    input  logic                   [LANE_W-1:0] up_i,
    input  logic                   [LANE_W-1:0] dn_i,
    input  omega_pkg::xchg_mode_e               mode_i,
    output logic                   [LANE_W-1:0] up_o,
    output logic                   [LANE_W-1:0] dn_o
);

    always_comb begin
        if (mode_i == omega_pkg::XCHG_CROSS) begin
            up_o = dn_i;
            dn_o = up_i;
        end else begin
            up_o = up_i;
            dn_o = dn_i;
        end
    end

endmodule

// File: rtl/omega_column.sv
`timescale 1ns/1ps
module omega_column #(
    parameter int N      = 8,
    parameter int LANE_W = 17
) (
    input  logic [N*LANE_W-1:0] lanes_i,
    input  logic                cross_i,
    output logic [N*LANE_W-1:0] lanes_o
);

    localparam int LG    = $clog2(N);
    localparam int PAIRS = N / 2;

    omega_pkg::xchg_mode_e col_mode;
    assign col_mode = cross_i ? omega_pkg::XCHG_CROSS : omega_pkg::XCHG_PASS;

    for (genvar k = 0; k < PAIRS; k++) begin : g_sw
        localparam int SRC_UP = omega_pkg::shuffle_src(2 * k, LG);
        localparam int SRC_DN = omega_pkg::shuffle_src(2 * k + 1, LG);
        omega_xchg #(.LANE_W(LANE_W)) u_sw (
            .up_i   (lanes_i[SRC_UP*LANE_W +: LANE_W]),
            .dn_i   (lanes_i[SRC_DN*LANE_W +: LANE_W]),
            .mode_i (col_mode),
            .up_o   (lanes_o[(2*k)*LANE_W +: LANE_W]),
            .dn_o   (lanes_o[(2*k+1)*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/omega_fabric.sv
`timescale 1ns/1ps
module omega_fabric #(
    parameter int N      = 8,
    parameter int LANE_W = 17
) (
    input  logic [N*LANE_W-1:0]  lanes_i,
    input  logic [$clog2(N)-1:0] route_i,
    output logic [N*LANE_W-1:0]  lanes_o
);

    localparam int LG = $clog2(N);

    logic [N*LANE_W-1:0] stage_w [LG+1];

    assign stage_w[0] = lanes_i;

    // The first column takes the top index bit; the last column takes bit 0.
    for (genvar s = 0; s < LG; s++) begin : g_col
        omega_column #(.N(N), .LANE_W(LANE_W)) u_col (
            .lanes_i (stage_w[s]),
            .cross_i (route_i[LG-1-s]),
            .lanes_o (stage_w[s+1])
        );
    end

    assign lanes_o = stage_w[LG];

endmodule

// File: rtl/omega_route_ctr.sv
`timescale 1ns/1ps
module omega_route_ctr #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [$clog2(N)-1:0] idx_o
);

    localparam int LG = $clog2(N);
    typedef logic [LG-1:0] idx_t;

    always_ff @(posedge clk) begin
        if (rst) idx_o <= '0;
        else     idx_o <= idx_o + 1'b1;
    end

    // R3: advances by exactly one each cycle, wrapping at N.
    p_step_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> idx_o == idx_t'($past(idx_o) + 1'b1));

endmodule

// File: rtl/rot_omega_net.sv
`timescale 1ns/1ps
module rot_omega_net #(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 16,
    parameter bit OUT_REG = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_PORTS-1:0]          req_valid_i,
    input  logic [N_PORTS*DATA_W-1:0]   req_data_i,
    output logic [N_PORTS-1:0]          req_valid_o,
    output logic [N_PORTS*DATA_W-1:0]   req_data_o,
    input  logic [N_PORTS-1:0]          rsp_valid_i,
    input  logic [N_PORTS*DATA_W-1:0]   rsp_data_i,
    output logic [N_PORTS-1:0]          rsp_valid_o,
    output logic [N_PORTS*DATA_W-1:0]   rsp_data_o,
    output logic [$clog2(N_PORTS)-1:0]  route_idx_o
);

    localparam int LANE_W = DATA_W + 1;
    localparam int BUS_W  = N_PORTS * LANE_W;

    logic [BUS_W-1:0] req_in_w, req_net_w, req_out_w;
    logic [BUS_W-1:0] rsp_in_w, rsp_net_w, rsp_out_w;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_pack
        assign req_in_w[p*LANE_W +: LANE_W] = {req_valid_i[p], req_data_i[p*DATA_W +: DATA_W]};
        assign rsp_in_w[p*LANE_W +: LANE_W] = {rsp_valid_i[p], rsp_data_i[p*DATA_W +: DATA_W]};
    end

    omega_route_ctr #(.N(N_PORTS)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .idx_o (route_idx_o)
    );

    omega_fabric #(.N(N_PORTS), .LANE_W(LANE_W)) u_req_net (
        .lanes_i (req_in_w),
        .route_i (route_idx_o),
        .lanes_o (req_net_w)
    );

    omega_fabric #(.N(N_PORTS), .LANE_W(LANE_W)) u_rsp_net (
        .lanes_i (rsp_in_w),
        .route_i (route_idx_o),
        .lanes_o (rsp_net_w)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                req_out_w <= '0;
                rsp_out_w <= '0;
            end else begin
                req_out_w <= req_net_w;
                rsp_out_w <= rsp_net_w;
            end
        end
    end else begin : g_comb
        assign req_out_w = req_net_w;
        assign rsp_out_w = rsp_net_w;
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_unpack
        assign req_valid_o[p]                 = req_out_w[p*LANE_W + DATA_W];
        assign req_data_o[p*DATA_W +: DATA_W] = req_out_w[p*LANE_W +: DATA_W];
        assign rsp_valid_o[p]                 = rsp_out_w[p*LANE_W + DATA_W];
        assign rsp_data_o[p*DATA_W +: DATA_W] = rsp_out_w[p*LANE_W +: DATA_W];
    end

    // Port-level routing checks, next to the output stage they observe.
    for (genvar j = 0; j < N_PORTS; j++) begin : g_chk
        if (OUT_REG) begin : g_r
            // R6: one cycle late, routed by the previous index.
            p_req_late_r6: assert property (@(posedge clk) disable iff (rst)
                !rst |=> req_data_o[j*DATA_W +: DATA_W]
                         == $past(req_data_i[(j ^ int'(route_idx_o))*DATA_W +: DATA_W]));
            p_rsp_late_r2: assert property (@(posedge clk) disable iff (rst)
                !rst |=> rsp_valid_o[j] == $past(rsp_valid_i[j ^ int'(route_idx_o)]));
        end else begin : g_c
            p_req_route_r1: assert property (@(posedge clk) disable iff (rst)
                req_data_o[j*DATA_W +: DATA_W]
                    == req_data_i[(j ^ int'(route_idx_o))*DATA_W +: DATA_W]);
            p_rsp_route_r2: assert property (@(posedge clk) disable iff (rst)
                rsp_valid_o[j] == rsp_valid_i[j ^ int'(route_idx_o)]);
        end
    end

    if (OUT_REG) begin : g_cnt_r
        p_valid_count_r5: assert property (@(posedge clk) disable iff (rst)
            !rst |=> $countones(req_valid_o) == $past($countones(req_valid_i)));
    end else begin : g_cnt_c
        p_valid_count_r5: assert property (@(posedge clk) disable iff (rst)
            $countones(req_valid_o) == $countones(req_valid_i));
    end

endmodule

// File: tb/rot_omega_net_tb_top.sv
`timescale 1ns/1ps
module rot_omega_net_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    // Eight-port combinational instance
    logic [7:0]   q8_vi, q8_vo, s8_vi, s8_vo;
    logic [127:0] q8_di, q8_do, s8_di, s8_do;
    logic [2:0]   idx8;
    // Two-port registered instance
    logic [1:0]   q2_vi, q2_vo, s2_vi, s2_vo;
    logic [15:0]  q2_di, q2_do, s2_di, s2_do;
    logic [0:0]   idx2;
    // Sixty-four-port combinational instance
    logic [63:0]  q64_vi, q64_vo, s64_vi, s64_vo;
    logic [511:0] q64_di, q64_do, s64_di, s64_do;
    logic [5:0]   idx64;

    rot_omega_net #(.N_PORTS(8), .DATA_W(16), .OUT_REG(1'b0)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid_i(q8_vi), .req_data_i(q8_di), .req_valid_o(q8_vo), .req_data_o(q8_do),
        .rsp_valid_i(s8_vi), .rsp_data_i(s8_di), .rsp_valid_o(s8_vo), .rsp_data_o(s8_do),
        .route_idx_o(idx8));

    rot_omega_net #(.N_PORTS(2), .DATA_W(8), .OUT_REG(1'b1)) reg_i (
        .clk(clk), .rst(rst),
        .req_valid_i(q2_vi), .req_data_i(q2_di), .req_valid_o(q2_vo), .req_data_o(q2_do),
        .rsp_valid_i(s2_vi), .rsp_data_i(s2_di), .rsp_valid_o(s2_vo), .rsp_data_o(s2_do),
        .route_idx_o(idx2));

    rot_omega_net #(.N_PORTS(64), .DATA_W(8), .OUT_REG(1'b0)) wide_i (
        .clk(clk), .rst(rst),
        .req_valid_i(q64_vi), .req_data_i(q64_di), .req_valid_o(q64_vo), .req_data_o(q64_do),
        .rsp_valid_i(s64_vi), .rsp_data_i(s64_di), .rsp_valid_o(s64_vo), .rsp_data_o(s64_do),
        .route_idx_o(idx64));

    // Entries: {valid mask, data tag}
    localparam logic [15:0] VEC [8] = '{16'hFF3C, 16'h0011, 16'hA57E, 16'h01C4,
                                        16'h8029, 16'h5AE0, 16'h0F96, 16'hF04B};

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) cyc = 0;
        else     cyc++;
        #1;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        q8_vi = '0; q8_di = '0; s8_vi = '0; s8_di = '0;
        q2_vi = '0; q2_di = '0; s2_vi = '0; s2_di = '0;
        q64_vi = '0; q64_di = '0; s64_vi = '0; s64_di = '0;

        repeat (3) step();
        chk(idx8 == 3'd0 && idx2 == 1'b0 && idx64 == 6'd0, "R3 index zero in reset",
            {idx8, idx2, idx64}, 0);
        chk(q2_vo == 2'b00 && q2_do == 16'h0, "R6 registered outputs clear in reset",
            {q2_vo, q2_do}, 0);
        rst = 1'b0;
        #1;
        chk(idx8 == 3'd0, "R3 index zero before first count", idx8, 0);

        // R3: count and wrap
        for (int t = 0; t < 10; t++) begin
            step();
            chk(idx8 == 3'(cyc % 8), "R3 eight-port index", idx8, cyc % 8);
            chk(idx2 == 1'(cyc % 2), "R3 two-port index", idx2, cyc % 2);
        end

        // Vector walk: R1, R2, R5
        for (int e = 0; e < 8; e++) begin
            logic [7:0]   mask, tag, ev, erv;
            logic [127:0] ed, erd;
            int k;
            step();
            mask = VEC[e][15:8];
            tag  = VEC[e][7:0];
            q8_vi = mask;
            s8_vi = ~mask;
            for (int i = 0; i < 8; i++) begin
                q8_di[i*16 +: 16] = {tag, 8'(i)};
                s8_di[i*16 +: 16] = {~tag, 8'(i + 8'h40)};
            end
            #1;
            k = cyc % 8;
            for (int j = 0; j < 8; j++) begin
                int src;
                src = j ^ k;
                ev[j]  = mask[src];
                erv[j] = ~mask[src];
                ed[j*16 +: 16]  = {tag, 8'(src)};
                erd[j*16 +: 16] = {~tag, 8'(src + 8'h40)};
            end
            chk(q8_vo == ev, "R5 request valid routing", q8_vo, ev);
            chk(q8_do == ed, "R1 request data routing", q8_do, ed);
            chk(s8_vo == erv && s8_do == erd, "R2 response routing", {s8_vo, s8_do}, {erv, erd});
        end
        q8_vi = '0;
        s8_vi = '0;

        // Registered two-port instance: R6 latency, R7 straight and cross, R2 return path
        for (int t = 0; t < 2; t++) begin
            logic [1:0]  prev_v, ev;
            logic [15:0] prev_d, ed;
            int k;
            prev_v = q2_vo;
            prev_d = q2_do;
            k = cyc % 2;
            q2_vi = (t == 0) ? 2'b10 : 2'b01;
            q2_di = (t == 0) ? 16'hB74D : 16'h19E2;
            s2_vi = 2'b10;
            s2_di = 16'hC301;
            #1;
            chk(q2_vo == prev_v && q2_do == prev_d, "R6 output holds within cycle",
                {q2_vo, q2_do}, {prev_v, prev_d});
            step();
            q2_vi = 2'b00;
            q2_di = 16'hFFFF;
            s2_vi = 2'b00;
            #1;
            if (k == 0) begin
                ev = (t == 0) ? 2'b10 : 2'b01;
                ed = (t == 0) ? 16'hB74D : 16'h19E2;
            end else begin
                ev = (t == 0) ? 2'b01 : 2'b10;
                ed = (t == 0) ? 16'h4DB7 : 16'hE219;
            end
            chk(q2_vo == ev && q2_do == ed, "R7 single column pass or swap", {q2_vo, q2_do}, {ev, ed});
            chk(s2_vo == ((k == 0) ? 2'b10 : 2'b01) && s2_do == ((k == 0) ? 16'hC301 : 16'h01C3),
                "R2 registered response path", {s2_vo, s2_do}, k);
        end

        // Mid-run reset: R3 and R6
        step();
        q2_vi = 2'b11;
        q2_di = 16'h5AA5;
        step();
        rst = 1'b1;
        step();
        chk(idx8 == 3'd0 && idx64 == 6'd0, "R3 mid-run reset clears index", {idx8, idx64}, 0);
        chk(q2_vo == 2'b00 && q2_do == 16'h0, "R6 reset clears registered outputs", {q2_vo, q2_do}, 0);
        rst = 1'b0;
        q2_vi = '0;

        // R4: full coverage over 64 cycles on the wide instance
        begin
            int seen [64][64];
            for (int a = 0; a < 64; a++)
                for (int b = 0; b < 64; b++) seen[a][b] = 0;
            q64_vi = '1;
            for (int i = 0; i < 64; i++) q64_di[i*8 +: 8] = 8'(i);
            for (int t = 0; t < 64; t++) begin
                step();
                for (int j = 0; j < 64; j++)
                    if (q64_vo[j]) seen[q64_do[j*8 +: 8]][j]++;
            end
            for (int a = 0; a < 64; a++) begin
                int bad;
                bad = 0;
                for (int b = 0; b < 64; b++) if (seen[a][b] != 1) bad++;
                chk(bad == 0, "R4 each input meets each output once", bad, 0);
            end
            q64_vi = 64'h0000_0000_0000_0001;
            #1;
            chk($countones(q64_vo) == 1 && q64_vo[cyc % 64] == 1'b1, "R5 single valid lane",
                q64_vo, 64'h1 << (cyc % 64));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule